// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a small processor core that runs in several operating modes. The eight low general registers, the program counter and the current status word exist once and are seen identically in every mode. The stack pointer and the link register are banked: each of the five privileged exception modes owns a private pair. User and System modes share one further pair. Each privileged exception mode also owns a saved status word. User and System modes have none.

A 5-bit mode input chooses the bank. Two read ports return data in the same cycle, from a 4-bit logical index. One write port commits on the rising clock edge. It is routed through the bank selected by the mode value present at that edge. The current status word has its own write port and output. The saved status word of the current mode has its own read, write and error signals.

Top module: `mode_banked_regfile`

## Requirements
- R1: Logical indices 0 to 7 address one set of eight registers common to all modes, so a value written in any mode is read back unchanged in every other mode.
- R2: Index 15 addresses a single program counter shared by all modes. Its value is also presented on `pc_o`, and it changes only through a write to index 15 (or reset).
- R3: Index 13 (stack pointer) and index 14 (link register) select a private copy for each of these modes: fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111 and undefined 5'b11011. User 5'b10000 and System 5'b11111 share one copy.
- R4: Any mode code not listed in R3 banks exactly as User mode does.
- R5: Indices 8 to 12 read as zero on both read ports, and writes to them change no register.
- R6: Each of the five privileged modes has its own saved status word. `spsr_rd_o` shows the word of the current mode, and `spsr_we_i` replaces that word on the rising edge.
- R7: In User, System or an unlisted mode, `spsr_rd_o` is zero and a saved-status write changes nothing. `spsr_err_o` is high in any such cycle where `spsr_re_i` or `spsr_we_i` is high, and low otherwise.
- R8: A register write takes effect at the rising edge, through the bank of the mode sampled at that edge. Reads are combinational and use the current mode.
- R9: When a read and a write address the same physical register in one cycle, the read returns the value held before the write.
- R10: A synchronous active-high reset clears every register to zero, except the current status word, which becomes 32'h0000_0013 (supervisor code in bits 4:0).
- R11: The current status word is one register for all modes. It is replaced on the rising edge when `cpsr_we_i` is high, and is always visible on `cpsr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode code |
| ra_idx_i | input | IDX_W | Read port A logical index |
| ra_data_o | output | DATA_W | Read port A data |
| rb_idx_i | input | IDX_W | Read port B logical index |
| rb_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | IDX_W | Register write logical index |
| wr_data_i | input | DATA_W | Register write data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | DATA_W | Current status write data |
| cpsr_o | output | DATA_W | Current status word |
| pc_o | output | DATA_W | Program counter value |
| spsr_re_i | input | 1 | Saved status read request |
| spsr_we_i | input | 1 | Saved status write enable |
| spsr_wdata_i | input | DATA_W | Saved status write data |
| spsr_rd_o | output | DATA_W | Saved status word of the current mode |
| spsr_err_o | output | 1 | Saved status access in a mode without one |

## Verification
The bench builds the block with its defaults: 32-bit data, eight low registers and a 4-bit index. With these values the unmapped window 8 to 12 sits between the low registers and the banked stack pointer, so random indices land in it often. Random mode codes include values outside the seven listed ones, which exercises the fallback to the shared bank. With only six banks, a few thousand random cycles revisit every banked copy many times. This brings cross-mode aliasing, unused-code banking and same-cycle read/write collisions within reach without a long run.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
    localparam int MODE_W = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    // Bank 0 is shared by User, System and every unlisted code.
    typedef enum logic [BANK_W-1:0] {
        BANK_SHARED = 3'd0,
        BANK_FIQ    = 3'd1,
        BANK_IRQ    = 3'd2,
        BANK_SVC    = 3'd3,
        BANK_ABT    = 3'd4,
        BANK_UND    = 3'd5
    } bank_e;
endpackage

// File: rtl/mbrf_mode_map.sv
module mbrf_mode_map
    import mbrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              priv_o
);
    always_comb begin
        unique case (mode_i)
            MODE_FIQ: bank_o = BANK_FIQ;
            MODE_IRQ: bank_o = BANK_IRQ;
            MODE_SVC: bank_o = BANK_SVC;
            MODE_ABT: bank_o = BANK_ABT;
            MODE_UND: bank_o = BANK_UND;
            default:  bank_o = BANK_SHARED;
        endcase
        priv_o = (bank_o != BANK_SHARED);
    end
endmodule

// File: rtl/mbrf_read_port.sv
module mbrf_read_port
    import mbrf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_LOW = 8,
    parameter int IDX_W   = 4
) (
    input  logic [IDX_W-1:0]                  idx_i,
    input  bank_e                             bank_i,
    input  logic [NUM_LOW-1:0][DATA_W-1:0]    low_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  sp_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  lr_i,
    input  logic [DATA_W-1:0]                 pc_i,
    output logic [DATA_W-1:0]                 data_o
);
    localparam int          TOP_IDX = (1 << IDX_W) - 1;
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(TOP_IDX);
    localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(TOP_IDX - 1);
    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(TOP_IDX - 2);

    always_comb begin
        data_o = '0;
        for (int i = 0; i < NUM_LOW; i++) begin
            if (idx_i == IDX_W'(i)) data_o = low_i[i];
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_i == bank_e'(b)) begin
                if (idx_i == SP_IDX) data_o = sp_i[b];
                if (idx_i == LR_IDX) data_o = lr_i[b];
            end
        end
        if (idx_i == PC_IDX) data_o = pc_i;
    end
endmodule

// File: rtl/mbrf_store.sv
module mbrf_store
    import mbrf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_LOW = 8,
    parameter int IDX_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  bank_e                             bank_i,
    input  logic                              wr_en_i,
    input  logic [IDX_W-1:0]                  wr_idx_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    input  logic                              cpsr_we_i,
    input  logic [DATA_W-1:0]                 cpsr_wdata_i,
    input  logic                              spsr_we_i,
    input  logic [DATA_W-1:0]                 spsr_wdata_i,
    output logic [NUM_LOW-1:0][DATA_W-1:0]    low_o,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]  sp_o,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]  lr_o,
    output logic [NUM_BANKS-1:1][DATA_W-1:0]  spsr_o,
    output logic [DATA_W-1:0]                 pc_o,
    output logic [DATA_W-1:0]                 cpsr_o
);
    localparam int          TOP_IDX = (1 << IDX_W) - 1;
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(TOP_IDX);
    localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(TOP_IDX - 1);
    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(TOP_IDX - 2);
    localparam logic [DATA_W-1:0] CPSR_RESET = DATA_W'(MODE_SVC);

    typedef struct packed {
        logic [NUM_LOW-1:0][DATA_W-1:0]   low;
        logic [NUM_BANKS-1:0][DATA_W-1:0] sp;
        logic [NUM_BANKS-1:0][DATA_W-1:0] lr;
        logic [NUM_BANKS-1:1][DATA_W-1:0] spsr;
        logic [DATA_W-1:0]                pc;
        logic [DATA_W-1:0]                cpsr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            for (int i = 0; i < NUM_LOW; i++) begin
                if (wr_idx_i == IDX_W'(i)) regs_d.low[i] = wr_data_i;
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_i == bank_e'(b)) begin
                    if (wr_idx_i == SP_IDX) regs_d.sp[b] = wr_data_i;
                    if (wr_idx_i == LR_IDX) regs_d.lr[b] = wr_data_i;
                end
            end
            if (wr_idx_i == PC_IDX) regs_d.pc = wr_data_i;
        end
        if (cpsr_we_i) regs_d.cpsr = cpsr_wdata_i;
        if (spsr_we_i) begin
            for (int b = 1; b < NUM_BANKS; b++) begin
                if (bank_i == bank_e'(b)) regs_d.spsr[b] = spsr_wdata_i;
            end
        end
        if (rst) begin
            regs_d      = '0;
            regs_d.cpsr = CPSR_RESET;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign low_o  = regs_q.low;
    assign sp_o   = regs_q.sp;
    assign lr_o   = regs_q.lr;
    assign spsr_o = regs_q.spsr;
    assign pc_o   = regs_q.pc;
    assign cpsr_o = regs_q.cpsr;
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
    import mbrf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_LOW = 8,
    parameter int IDX_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [IDX_W-1:0]     ra_idx_i,
    output logic [DATA_W-1:0]    ra_data_o,
    input  logic [IDX_W-1:0]     rb_idx_i,
    output logic [DATA_W-1:0]    rb_data_o,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 cpsr_we_i,
    input  logic [DATA_W-1:0]    cpsr_wdata_i,
    output logic [DATA_W-1:0]    cpsr_o,
    output logic [DATA_W-1:0]    pc_o,
    input  logic                 spsr_re_i,
    input  logic                 spsr_we_i,
    input  logic [DATA_W-1:0]    spsr_wdata_i,
    output logic [DATA_W-1:0]    spsr_rd_o,
    output logic                 spsr_err_o
);
    localparam int NUM_RD = 2;

    bank_e bank;
    logic  priv;

    logic [NUM_LOW-1:0][DATA_W-1:0]   low_v;
    logic [NUM_BANKS-1:0][DATA_W-1:0] sp_v;
    logic [NUM_BANKS-1:0][DATA_W-1:0] lr_v;
    logic [NUM_BANKS-1:1][DATA_W-1:0] spsr_v;
    logic [NUM_RD-1:0][IDX_W-1:0]     rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0]    rd_data;

    mbrf_mode_map u_map (
        .mode_i (mode_i),
        .bank_o (bank),
        .priv_o (priv)
    );

    mbrf_store #(
        .DATA_W  (DATA_W),
        .NUM_LOW (NUM_LOW),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .bank_i       (bank),
        .wr_en_i      (wr_en_i),
        .wr_idx_i     (wr_idx_i),
        .wr_data_i    (wr_data_i),
        .cpsr_we_i    (cpsr_we_i),
        .cpsr_wdata_i (cpsr_wdata_i),
        .spsr_we_i    (spsr_we_i && priv),
        .spsr_wdata_i (spsr_wdata_i),
        .low_o        (low_v),
        .sp_o         (sp_v),
        .lr_o         (lr_v),
        .spsr_o       (spsr_v),
        .pc_o         (pc_o),
        .cpsr_o       (cpsr_o)
    );

    assign rd_idx = {rb_idx_i, ra_idx_i};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        mbrf_read_port #(
            .DATA_W  (DATA_W),
            .NUM_LOW (NUM_LOW),
            .IDX_W   (IDX_W)
        ) u_rd (
            .idx_i  (rd_idx[p]),
            .bank_i (bank),
            .low_i  (low_v),
            .sp_i   (sp_v),
            .lr_i   (lr_v),
            .pc_i   (pc_o),
            .data_o (rd_data[p])
        );
    end

    assign ra_data_o = rd_data[0];
    assign rb_data_o = rd_data[1];

    always_comb begin
        spsr_rd_o = '0;
        for (int b = 1; b < NUM_BANKS; b++) begin
            if (bank == bank_e'(b)) spsr_rd_o = spsr_v[b];
        end
        spsr_err_o = (spsr_re_i || spsr_we_i) && !priv;
    end
endmodule

// File: rtl/mbrf_checker.sv
module mbrf_checker
    import mbrf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_LOW = 8,
    parameter int IDX_W   = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [MODE_W-1:0]    mode_i,
    input logic [IDX_W-1:0]     ra_idx_i,
    input logic [DATA_W-1:0]    ra_data_o,
    input logic                 wr_en_i,
    input logic [IDX_W-1:0]     wr_idx_i,
    input logic [DATA_W-1:0]    wr_data_i,
    input logic                 cpsr_we_i,
    input logic [DATA_W-1:0]    cpsr_wdata_i,
    input logic [DATA_W-1:0]    cpsr_o,
    input logic [DATA_W-1:0]    pc_o,
    input logic [DATA_W-1:0]    spsr_rd_o,
    input logic                 spsr_err_o
);
    localparam int          TOP_IDX = (1 << IDX_W) - 1;
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(TOP_IDX);
    localparam int          GAP_HI  = TOP_IDX - 3;

    logic priv_code;
    assign priv_code = (mode_i == MODE_FIQ) || (mode_i == MODE_IRQ) ||
                       (mode_i == MODE_SVC) || (mode_i == MODE_ABT) ||
                       (mode_i == MODE_UND);

    a_r10_reset_cpsr: assert property (@(posedge clk)
        rst |=> (cpsr_o == DATA_W'(MODE_SVC)));

    a_r10_reset_pc: assert property (@(posedge clk)
        rst |=> (pc_o == '0));

    a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
        spsr_err_o |-> (spsr_rd_o == '0));

    a_r7_err_unpriv: assert property (@(posedge clk) disable iff (rst)
        spsr_err_o |-> !priv_code);

    a_r5_gap_zero: assert property (@(posedge clk) disable iff (rst)
        ((int'(ra_idx_i) >= NUM_LOW) && (int'(ra_idx_i) <= GAP_HI)) |-> (ra_data_o == '0));

    a_r2_pc_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i == PC_IDX) |=> (pc_o == $past(wr_data_i)));

    a_r2_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && wr_idx_i == PC_IDX) |=> $stable(pc_o));

    a_r11_cpsr_write: assert property (@(posedge clk) disable iff (rst)
        cpsr_we_i |=> (cpsr_o == $past(cpsr_wdata_i)));

    a_r9_pc_read_old: assert property (@(posedge clk) disable iff (rst)
        (ra_idx_i == PC_IDX && wr_en_i && wr_idx_i == PC_IDX) |-> (ra_data_o == pc_o));
endmodule

bind mode_banked_regfile mbrf_checker #(
    .DATA_W  (DATA_W),
    .NUM_LOW (NUM_LOW),
    .IDX_W   (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .ra_idx_i     (ra_idx_i),
    .ra_data_o    (ra_data_o),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_data_i    (wr_data_i),
    .cpsr_we_i    (cpsr_we_i),
    .cpsr_wdata_i (cpsr_wdata_i),
    .cpsr_o       (cpsr_o),
    .pc_o         (pc_o),
    .spsr_rd_o    (spsr_rd_o),
    .spsr_err_o   (spsr_err_o)
);

// File: tb/sim_mode_banked_regfile.sv
`timescale 1ns/1ps
module sim_mode_banked_regfile;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    mode = 5'b10000;
    logic [IW-1:0] ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic [DW-1:0] ra_data, rb_data, wr_data = '0;
    logic          wr_en = 1'b0, cpsr_we = 1'b0, spsr_re = 1'b0, spsr_we = 1'b0;
    logic [DW-1:0] cpsr_wdata = '0, spsr_wdata = '0;
    logic [DW-1:0] cpsr, pc, spsr_rd;
    logic          spsr_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] m_low [8];
    logic [DW-1:0] m_sp  [6];
    logic [DW-1:0] m_lr  [6];
    logic [DW-1:0] m_spsr[6];
    logic [DW-1:0] m_pc, m_cpsr;

    logic [4:0] mode_list [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                  5'b10111, 5'b11011, 5'b11111};

    always #2.5 clk = ~clk;

    mode_banked_regfile u0 (
        .clk (clk), .rst (rst), .mode_i (mode),
        .ra_idx_i (ra_idx), .ra_data_o (ra_data),
        .rb_idx_i (rb_idx), .rb_data_o (rb_data),
        .wr_en_i (wr_en), .wr_idx_i (wr_idx), .wr_data_i (wr_data),
        .cpsr_we_i (cpsr_we), .cpsr_wdata_i (cpsr_wdata), .cpsr_o (cpsr),
        .pc_o (pc),
        .spsr_re_i (spsr_re), .spsr_we_i (spsr_we), .spsr_wdata_i (spsr_wdata),
        .spsr_rd_o (spsr_rd), .spsr_err_o (spsr_err)
    );

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_read(logic [IW-1:0] idx, logic [4:0] m);
        if (idx < 8)   return m_low[idx[2:0]];
        if (idx == 13) return m_sp[bank_of(m)];
        if (idx == 14) return m_lr[bank_of(m)];
        if (idx == 15) return m_pc;
        return '0;
    endfunction

    function automatic string tag_of(logic [IW-1:0] idx, logic [4:0] m);
        if (idx < 8) return "R1";
        if (idx == 15) return "R2";
        if (idx == 13 || idx == 14) return (bank_of(m) == 0 && m != 5'b10000 && m != 5'b11111) ? "R4" : "R3";
        return "R5";
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_low[i] = '0;
        for (int b = 0; b < 6; b++) begin
            m_sp[b] = '0; m_lr[b] = '0; m_spsr[b] = '0;
        end
        m_pc = '0;
        m_cpsr = 32'h0000_0013;
    endtask

    // Inputs are set at the falling edge; reads checked 1 ns later (before
    // the write lands, R9), then the model commits after the rising edge (R8).
    task automatic tick();
        int bk;
        bk = bank_of(mode);
        #1;
        check(tag_of(ra_idx, mode), ra_data, exp_read(ra_idx, mode));
        check(tag_of(rb_idx, mode), rb_data, exp_read(rb_idx, mode));
        check("R2", pc, m_pc);
        check("R11", cpsr, m_cpsr);
        check(bk == 0 ? "R7" : "R6", spsr_rd, bk == 0 ? '0 : m_spsr[bk]);
        check("R7", DW'(spsr_err), DW'((spsr_re || spsr_we) && bk == 0));
        @(posedge clk);
        if (wr_en) begin
            if (wr_idx < 8) m_low[wr_idx[2:0]] = wr_data;
            else if (wr_idx == 13) m_sp[bk] = wr_data;
            else if (wr_idx == 14) m_lr[bk] = wr_data;
            else if (wr_idx == 15) m_pc = wr_data;
        end
        if (cpsr_we) m_cpsr = cpsr_wdata;
        if (spsr_we && bk != 0) m_spsr[bk] = spsr_wdata;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; cpsr_we = 0; spsr_we = 0; spsr_re = 0;
    endtask

    task automatic wr(logic [4:0] m, logic [IW-1:0] idx, logic [DW-1:0] d);
        idle(); mode = m; wr_en = 1; wr_idx = idx; wr_data = d; tick();
    endtask

    task automatic rd(logic [4:0] m, logic [IW-1:0] a, logic [IW-1:0] b);
        idle(); mode = m; ra_idx = a; rb_idx = b; tick();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10: reset state seen from every mode
        for (int m = 0; m < 7; m++) begin
            for (int i = 0; i < 16; i += 2) begin
                idle(); mode = mode_list[m]; ra_idx = IW'(i); rb_idx = IW'(i + 1);
                #1;
                check("R10", ra_data, '0);
                check("R10", rb_data, '0);
                @(negedge clk);
            end
        end
        check("R10", cpsr, 32'h0000_0013);

        // R1: low register written in FIQ, visible in User and Abort
        wr(5'b10001, 4'd3, 32'hA5A5_0003);
        rd(5'b10000, 4'd3, 4'd3);
        rd(5'b10111, 4'd3, 4'd0);

        // R3: distinct SP/LR per mode, User and System share
        for (int m = 0; m < 7; m++) begin
            wr(mode_list[m], 4'd13, 32'h5000_0000 + m);
            wr(mode_list[m], 4'd14, 32'h1000_0000 + m);
        end
        for (int m = 0; m < 7; m++) rd(mode_list[m], 4'd13, 4'd14);
        idle(); mode = 5'b10000; ra_idx = 13; #1;
        check("R3", ra_data, 32'h5000_0006);
        @(negedge clk);

        // R4: unlisted code banks with User
        wr(5'b00000, 4'd13, 32'hDEAD_0004);
        rd(5'b10000, 4'd13, 4'd14);
        rd(5'b11111, 4'd13, 4'd13);

        // R5: gap indices ignore writes and read zero
        for (int i = 8; i <= 12; i++) wr(5'b10011, IW'(i), 32'hFFFF_FFFF);
        for (int i = 8; i <= 12; i++) rd(5'b10011, IW'(i), 4'd7);

        // R6/R7: saved status per mode, ignored in User/System
        for (int m = 1; m < 6; m++) begin
            idle(); mode = mode_list[m]; spsr_we = 1; spsr_wdata = 32'h0600_0000 + m; tick();
        end
        idle(); mode = 5'b10000; spsr_we = 1; spsr_wdata = 32'hBAD0_0001; tick();
        idle(); mode = 5'b11111; spsr_re = 1; tick();
        for (int m = 1; m < 6; m++) begin
            idle(); mode = mode_list[m]; spsr_re = 1; tick();
        end

        // R9: read and write same register same cycle
        idle(); mode = 5'b10010; ra_idx = 14; rb_idx = 15;
        wr_en = 1; wr_idx = 14; wr_data = 32'h9999_0014; tick();
        idle(); mode = 5'b10010; ra_idx = 15; wr_en = 1; wr_idx = 15; wr_data = 32'h0000_8000; tick();
        rd(5'b10010, 4'd14, 4'd15);

        // R11: status word shared
        idle(); mode = 5'b10001; cpsr_we = 1; cpsr_wdata = 32'h6000_00D1; tick();
        rd(5'b10000, 4'd0, 4'd1);

        // R8: random traffic across modes
        for (int n = 0; n < 3000; n++) begin
            idle();
            if ($urandom_range(0, 9) == 0) mode = 5'($urandom);
            else mode = mode_list[$urandom_range(0, 6)];
            ra_idx = IW'($urandom); rb_idx = IW'($urandom);
            wr_en = ($urandom_range(0, 2) != 0);
            wr_idx = IW'($urandom); wr_data = $urandom;
            cpsr_we = ($urandom_range(0, 7) == 0); cpsr_wdata = $urandom;
            spsr_re = $urandom_range(0, 1); spsr_we = ($urandom_range(0, 3) == 0);
            spsr_wdata = $urandom;
            tick();
        end

        // R10: reset mid-run clears state
        idle(); rst = 1; @(negedge clk); rst = 0; model_reset();
        rd(5'b10011, 4'd13, 4'd3);
        rd(5'b10001, 4'd15, 4'd14);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule